// File: doc/BRIEF.md
# PS/2 host transceiver

This block is the host end of a two-wire open-drain PS/2 link to a mouse or keyboard. Both the clock and the data line are pulled low through active-low drive outputs, where 0 pulls the line down and 1 lets it float high. The device always generates the clock. The block samples and updates data only on falling edges of that clock, after passing both lines through a two-flop synchronizer.

Device frames are checked for start, parity and stop errors. Good bytes go into an 8-entry receive FIFO that software-side logic drains through a pop port.

A command byte is sent with a one-cycle start strobe. The block then runs the host request sequence: it holds the clock low, pulls data low, releases the clock, shifts the byte out on the device's clocks, checks the acknowledge, and waits for the bus to return high. Every failure produces a one-cycle error pulse with a 2-bit code. After any failure the block inhibits the bus for a recovery time and then returns to idle. Reset also enters that recovery time.

All durations are given in microseconds and turned into cycle counts from the system clock frequency parameter.

Top module: `ps2_host_xcvr`

## Requirements
- R1: After reset the clock output is 0 (bus inhibited), the data output is 1 and busy is 1 for RECOVER_US; then both outputs are 1 and busy is 0.
- R2: In idle, a falling clock edge with data 0 starts a receive. The next 8 edges give data bits, least significant first. A good frame's byte appears on rx_data with rx_valid 1, rx_pop removes it, and the data output stays 1 while receiving.
- R3: In idle, a falling clock edge with data 1 raises err_pulse with err_code 0 (start error) and stores nothing.
- R4: A parity bit that leaves an even count of ones among the 9 bits gives err_code 1. A stop bit of 0 gives err_code 2. Neither stores a byte.
- R5: The FIFO holds 8 bytes in arrival order. A good frame arriving when it is full is dropped and sets rx_overflow, which stays 1 until reset.
- R6: tx_start in idle holds the clock output at 0 and the data output at 1 for REQ_US, then sets the clock output to 1 and the data output to 0.
- R7: On the next 8 falling edges the data output presents tx_data least significant bit first. On the 9th edge it presents the odd parity bit, and on the 10th edge it is released to 1 as the stop bit.
- R8: If the data line is 1 at the 11th falling edge (no acknowledge), err_code 2 is raised.
- R9: After an acknowledge, both lines are polled every POLL_US up to POLL_MAX times. Both high gives a one-cycle tx_done and idle; otherwise err_code 3 is raised.
- R10: A transmit not finished WDOG_US after tx_start raises err_code 3.
- R11: err_pulse lasts one cycle. After it, the clock output is 0 and the data output is 1 for RECOVER_US, then the block is idle with both lines released.
- R12: tx_start while busy is ignored: no request sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | PS/2 clock line level |
| ps2_dat_in | input | 1 | PS/2 data line level |
| ps2_clk_o | output | 1 | Clock drive, 0 pulls the line low |
| ps2_dat_o | output | 1 | Data drive, 0 pulls the line low |
| tx_data | input | 8 | Byte to send, captured with tx_start |
| tx_start | input | 1 | One-cycle transmit request, honoured only in idle |
| busy | output | 1 | Block not idle |
| tx_done | output | 1 | One-cycle pulse at successful transmit end |
| err_pulse | output | 1 | One-cycle pulse on any error |
| err_code | output | 2 | 0 start, 1 parity, 2 stop/acknowledge, 3 timeout |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_data | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Remove oldest byte |
| rx_overflow | output | 1 | Sticky flag: a byte was dropped on a full FIFO |

## Verification
The bench sets CLK_HZ to 1000000, which makes one cycle stand for one microsecond. It also shortens RECOVER_US to 200 and WDOG_US to 1000. The request time and the 2 µs by 50 poll window keep their default values. With these settings the request timing, the recovery window, the post-acknowledge timeout and the transmit watchdog can all be reached and measured to the cycle within a few thousand clocks.

// File: rtl/ps2_host_xcvr.sv
module ps2_host_xcvr #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int REQ_US     = 128,
  parameter int POLL_US    = 2,
  parameter int POLL_MAX   = 50,
  parameter int RECOVER_US = 1000,
  parameter int WDOG_US    = 163_000,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_o,
  output logic       ps2_dat_o,
  input  logic [7:0] tx_data,
  input  logic       tx_start,
  output logic       busy,
  output logic       tx_done,
  output logic       err_pulse,
  output logic [1:0] err_code,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic       rx_pop,
  output logic       rx_overflow
);
  localparam int CPU      = CLK_HZ / 1_000_000;
  localparam int REQ_CYC  = CPU * REQ_US;
  localparam int POLL_CYC = CPU * POLL_US;
  localparam int REC_CYC  = CPU * RECOVER_US;
  localparam int WD_CYC   = CPU * WDOG_US;
  localparam int T1       = (REQ_CYC > POLL_CYC) ? REQ_CYC : POLL_CYC;
  localparam int TMAX     = (T1 > REC_CYC) ? T1 : REC_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int WW       = $clog2(WD_CYC + 1);
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int AW       = $clog2(FIFO_DEPTH);
  localparam int CW       = $clog2(FIFO_DEPTH + 1);

  localparam logic [TW-1:0] REQ_LD    = TW'(REQ_CYC - 1);
  localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);
  localparam logic [TW-1:0] REC_LD    = TW'(REC_CYC - 1);
  localparam logic [WW-1:0] WD_LD     = WW'(WD_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
  localparam logic [AW-1:0] PTR_LAST  = AW'(FIFO_DEPTH - 1);

  localparam logic [1:0] E_START = 2'd0;
  localparam logic [1:0] E_PAR   = 2'd1;
  localparam logic [1:0] E_FRAME = 2'd2;
  localparam logic [1:0] E_TIME  = 2'd3;

  typedef enum logic [3:0] {
    IDLE, RX_DATA, RX_PAR, RX_STOP,
    TX_REQ, TX_DATA, TX_PAR, TX_STOP, TX_ACK, TX_END,
    RECOVER
  } st_t;

  st_t           st;
  logic [2:0]    cs;
  logic [1:0]    ds;
  logic [TW-1:0] tmr;
  logic [WW-1:0] wd;
  logic [PW-1:0] pcnt;
  logic [2:0]    bcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic          tx_par;
  logic          fail;
  logic [1:0]    ecode;

  wire fall       = cs[2] & ~cs[1];
  wire din        = ds[1];
  wire lines_high = cs[1] & ds[1];
  wire wd_on      = (st == TX_REQ) || (st == TX_DATA) || (st == TX_PAR) ||
                    (st == TX_STOP) || (st == TX_ACK) || (st == TX_END);

  assign busy      = (st != IDLE);
  assign ps2_clk_o = !((st == TX_REQ) || (st == RECOVER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= 3'b111;
      ds <= 2'b11;
    end else begin
      cs <= {cs[1:0], ps2_clk_in};
      ds <= {ds[0], ps2_dat_in};
    end
  end

  always_comb begin
    fail  = 1'b0;
    ecode = E_TIME;
    case (st)
      IDLE:    if (!tx_start && fall && din) begin fail = 1'b1; ecode = E_START; end
      RX_PAR:  if (fall && !(^{rx_sh, din})) begin fail = 1'b1; ecode = E_PAR; end
      RX_STOP: if (fall && !din) begin fail = 1'b1; ecode = E_FRAME; end
      TX_ACK:  if (fall && din) begin fail = 1'b1; ecode = E_FRAME; end
      TX_END:  if (tmr == '0 && !lines_high && pcnt == POLL_LAST) fail = 1'b1;
      default: ;
    endcase
    if (wd_on && wd == '0) begin
      fail  = 1'b1;
      ecode = E_TIME;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RECOVER;
      tmr       <= REC_LD;
      wd        <= WD_LD;
      pcnt      <= '0;
      bcnt      <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_par    <= 1'b0;
      ps2_dat_o <= 1'b1;
      tx_done   <= 1'b0;
      err_pulse <= 1'b0;
      err_code  <= E_START;
    end else begin
      tx_done   <= 1'b0;
      err_pulse <= fail;
      if (fail) err_code <= ecode;

      if (st == IDLE) wd <= WD_LD;
      else if (wd_on && wd != '0) wd <= wd - 1'b1;

      if (fail) begin
        st        <= RECOVER;
        tmr       <= REC_LD;
        ps2_dat_o <= 1'b1;
      end else begin
        case (st)
          IDLE: begin
            if (tx_start) begin
              st     <= TX_REQ;
              tmr    <= REQ_LD;
              tx_sh  <= tx_data;
              tx_par <= ~^tx_data;
            end else if (fall) begin
              st   <= RX_DATA;
              bcnt <= '0;
            end
          end
          RX_DATA: if (fall) begin
            rx_sh <= {din, rx_sh[7:1]};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) st <= RX_PAR;
          end
          RX_PAR:  if (fall) st <= RX_STOP;
          RX_STOP: if (fall) st <= IDLE;
          TX_REQ: begin
            if (tmr == '0) begin
              ps2_dat_o <= 1'b0;
              bcnt      <= '0;
              st        <= TX_DATA;
            end else tmr <= tmr - 1'b1;
          end
          TX_DATA: if (fall) begin
            ps2_dat_o <= tx_sh[0];
            tx_sh     <= tx_sh >> 1;
            bcnt      <= bcnt + 3'd1;
            if (bcnt == 3'd7) st <= TX_PAR;
          end
          TX_PAR: if (fall) begin
            ps2_dat_o <= tx_par;
            st        <= TX_STOP;
          end
          TX_STOP: if (fall) begin
            ps2_dat_o <= 1'b1;
            st        <= TX_ACK;
          end
          TX_ACK: if (fall) begin
            st   <= TX_END;
            tmr  <= POLL_LD;
            pcnt <= '0;
          end
          TX_END: begin
            if (tmr == '0) begin
              if (lines_high) begin
                st      <= IDLE;
                tx_done <= 1'b1;
              end else begin
                pcnt <= pcnt + 1'b1;
                tmr  <= POLL_LD;
              end
            end else tmr <= tmr - 1'b1;
          end
          RECOVER: begin
            if (tmr == '0) st <= IDLE;
            else tmr <= tmr - 1'b1;
          end
          default: st <= RECOVER;
        endcase
      end
    end
  end

  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire push    = (st == RX_STOP) && fall && din;
  wire full    = (cnt == CW'(FIFO_DEPTH));
  wire do_push = push && !full;
  wire do_pop  = rx_pop && rx_valid;

  assign rx_valid = (cnt != '0);
  assign rx_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp          <= '0;
      rp          <= '0;
      cnt         <= '0;
      rx_overflow <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (push && full) rx_overflow <= 1'b1;
    end
  end

  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH));
  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);
  assert_err_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  assert_err_inhibits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!ps2_clk_o && ps2_dat_o));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!busy && ps2_dat_o && ps2_clk_o));
  assert_rx_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_DATA || st == RX_PAR || st == RX_STOP) |-> ps2_dat_o);
  assert_req_from_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && st != TX_REQ) |=> (st != TX_REQ));
endmodule

// File: tb/tb_ps2_host_xcvr.sv
module tb_ps2_host_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_start = 1'b0, rx_pop = 1'b0;
  logic ps2_clk_o, ps2_dat_o, busy, tx_done, err_pulse, rx_valid, rx_overflow;
  logic [1:0] err_code;
  logic [7:0] rx_data;

  wire line_clk = dev_clk & ps2_clk_o;
  wire line_dat = dev_dat & ps2_dat_o;

  int total = 0, bad = 0, err_seen = 0, done_seen = 0, cycles = 0;
  logic [1:0] last_code = '0;
  bit finished = 0;

  ps2_host_xcvr #(.CLK_HZ(1_000_000), .RECOVER_US(200), .WDOG_US(1000)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(line_clk), .ps2_dat_in(line_dat),
    .ps2_clk_o(ps2_clk_o), .ps2_dat_o(ps2_dat_o), .tx_data(tx_data), .tx_start(tx_start),
    .busy(busy), .tx_done(tx_done), .err_pulse(err_pulse), .err_code(err_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop), .rx_overflow(rx_overflow));

  always #10 clk = ~clk;

  // {bad stop, bad parity, byte}
  localparam logic [9:0] VECS [6] = '{10'h000, 10'h0A5, 10'h0FF, 10'h13C, 10'h281, 10'h05A};

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && err_pulse) begin err_seen++; last_code = err_code; end
    if (rst_n && tx_done) done_seen++;
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    check(0, "idle timeout", 1, 0);
  endtask

  task automatic pop();
    rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit sbad, input bit pbad, input bit stbad);
    for (int i = 0; i < 11; i++) begin
      if (i == 0) dev_dat = sbad;
      else if (i <= 8) dev_dat = b[i-1];
      else if (i == 9) dev_dat = (~^b) ^ pbad;
      else dev_dat = !stbad;
      cyc(4); dev_clk = 1'b0; cyc(8); dev_clk = 1'b1; cyc(4);
    end
    dev_dat = 1'b1;
  endtask

  task automatic start_tx(input logic [7:0] b);
    tx_data = b; tx_start = 1'b1; cyc(1); tx_start = 1'b0;
  endtask

  task automatic dev_receive(output logic [9:0] bits, input bit ack, input int hold);
    for (int i = 0; i < 3000; i++) begin
      if (ps2_clk_o && !ps2_dat_o) break;
      @(negedge clk);
    end
    cyc(4);
    for (int i = 0; i < 10; i++) begin
      dev_clk = 1'b0; cyc(8); dev_clk = 1'b1;
      bits[i] = line_dat;
      cyc(8);
    end
    dev_dat = !ack; cyc(2);
    dev_clk = 1'b0; cyc(8); dev_clk = 1'b1; cyc(4);
    if (hold > 0) cyc(hold);
    dev_dat = 1'b1;
  endtask

  task automatic tx_good(input logic [7:0] b);
    int n, d0, e0;
    logic [9:0] bits;
    d0 = done_seen; e0 = err_seen;
    start_tx(b);
    n = 0;
    while (!ps2_clk_o && n < 400) begin
      if (!ps2_dat_o) check(0, "R6 data released in request", 0, 1);
      n++; cyc(1);
    end
    check(n >= 126 && n <= 130, "R6 request length", n, 128);
    check(ps2_dat_o == 1'b0, "R6 data pulled after request", ps2_dat_o, 0);
    dev_receive(bits, 1'b1, 0);
    check(bits[7:0] == b, "R7 sent byte", bits[7:0], b);
    check(^bits[8:0] == 1'b1, "R7 odd parity", bits[8], ~^b);
    check(bits[9] == 1'b1, "R7 stop released", bits[9], 1);
    cyc(150);
    check(done_seen == d0 + 1, "R9 tx_done", done_seen - d0, 1);
    check(err_seen == e0 && !busy, "R9 no error after ack", err_seen - e0, 0);
  endtask

  initial begin
    logic [9:0] bits;
    int e0, n;
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    check(ps2_clk_o == 0, "R1 clock inhibited at reset", ps2_clk_o, 0);
    check(ps2_dat_o == 1 && busy == 1, "R1 data released busy", {ps2_dat_o, busy}, 3);
    check(!rx_valid && !rx_overflow, "R1 fifo empty", {rx_valid, rx_overflow}, 0);
    start_tx(8'hAA);
    cyc(150);
    check(ps2_clk_o == 0, "R1 still inhibited", ps2_clk_o, 0);
    wait_idle();
    check(ps2_clk_o == 1 && ps2_dat_o == 1, "R1 released after recovery", {ps2_clk_o, ps2_dat_o}, 3);
    cyc(150);
    check(ps2_clk_o == 1 && !busy, "R12 start while busy ignored", {ps2_clk_o, busy}, 2);

    foreach (VECS[k]) begin
      e0 = err_seen;
      send_frame(VECS[k][7:0], 1'b0, VECS[k][8], VECS[k][9]);
      cyc(2);
      wait_idle();
      if (VECS[k][8]) begin
        check(err_seen == e0 + 1 && last_code == 2'd1, "R4 parity error", last_code, 1);
        check(!rx_valid, "R4 nothing stored", rx_valid, 0);
      end else if (VECS[k][9]) begin
        check(err_seen == e0 + 1 && last_code == 2'd2, "R4 stop error", last_code, 2);
        check(!rx_valid, "R4 nothing stored", rx_valid, 0);
      end else begin
        check(rx_valid && rx_data == VECS[k][7:0], "R2 received byte", rx_data, VECS[k][7:0]);
        check(err_seen == e0, "R2 no error", err_seen - e0, 0);
        pop(); cyc(1);
        check(!rx_valid, "R2 pop empties", rx_valid, 0);
      end
    end

    e0 = err_seen;
    send_frame(8'h12, 1'b1, 1'b0, 1'b0);
    wait_idle();
    check(err_seen == e0 + 1 && last_code == 2'd0, "R3 start error", last_code, 0);
    check(!rx_valid, "R3 nothing stored", rx_valid, 0);

    for (int i = 0; i < 9; i++) begin
      send_frame(8'(i * 17 + 3), 1'b0, 1'b0, 1'b0);
      cyc(2);
      if (i == 7) check(!rx_overflow, "R5 no overflow at 8", rx_overflow, 0);
    end
    check(rx_overflow, "R5 overflow set", rx_overflow, 1);
    for (int i = 0; i < 8; i++) begin
      check(rx_valid && rx_data == 8'(i * 17 + 3), "R5 fifo order", rx_data, i * 17 + 3);
      pop(); cyc(1);
    end
    check(!rx_valid && rx_overflow, "R5 ninth dropped, flag sticky", {rx_valid, rx_overflow}, 1);

    tx_good(8'hF4);
    tx_good(8'h01);
    tx_good(8'hFF);

    e0 = err_seen;
    start_tx(8'h55);
    dev_receive(bits, 1'b0, 0);
    cyc(5);
    check(err_seen == e0 + 1 && last_code == 2'd2, "R8 missing ack", last_code, 2);
    wait_idle();

    e0 = err_seen;
    start_tx(8'h33);
    dev_receive(bits, 1'b1, 300);
    check(err_seen == e0 + 1 && last_code == 2'd3, "R9 post-ack timeout", last_code, 3);
    wait_idle();

    e0 = err_seen;
    start_tx(8'h77);
    cyc(949);
    check(err_seen == e0, "R10 no early watchdog", err_seen - e0, 0);
    while (err_seen == e0 && n < 200) begin n++; cyc(1); end
    check(err_seen == e0 + 1 && last_code == 2'd3, "R10 watchdog error", last_code, 3);
    n = 0;
    while (!ps2_clk_o && n < 400) begin
      if (!ps2_dat_o) check(0, "R11 data released in recovery", 0, 1);
      n++; cyc(1);
    end
    check(n >= 197 && n <= 202, "R11 recovery length", n, 200);
    check(!busy, "R11 idle after recovery", busy, 0);

    finish_run();
  end
endmodule